// File: doc/BRIEF.md
# Lane Drive-Level Adjustment Unit

This block turns the drive-adjust requests that a serial link receiver reports for each lane into one transmit setting, and every lane of the link uses that setting. The request word holds a 2-bit voltage-swing request and a 2-bit pre-emphasis request for each of four lanes. Only the lanes below the active lane count take part. The unit takes the worst case of each field across those lanes. It clamps the swing against a platform maximum. It then clamps the pre-emphasis against a ceiling that depends on the clamped swing. The result is written as a training byte that carries "maximum reached" flag bits.

A controller presents the request word, the lane count and the swing limit, then pulses `start`. On the next cycle the unit shows the four lane bytes and the all-lanes-at-maximum-swing flag, with `done` high for exactly one cycle. The outputs hold until the next operation.

The controller is a two-state machine. `ST_IDLE` waits for work. The transition `T_ACCEPT` (start seen in `ST_IDLE`) loads the lane bytes and moves to `ST_REPORT`, where `done` is high. The transition `T_RETURN` always leads from `ST_REPORT` back to `ST_IDLE`, and any start seen during `ST_REPORT` is dropped.

Top module: `lane_drive_adjust`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four lane bytes to 0x00 and drives `done` and `all_max_swing` low.
- R2: A `start` sampled while idle makes `done` high on the following cycle, and the new outputs are visible in that same cycle. `done` is high for exactly one cycle and is never high unless `start` was sampled on the previous edge.
- R3: Lane i's swing request sits in `req_word[4i+1:4i]` and its pre-emphasis request in `req_word[4i+3:4i+2]`. Only lanes with index below `lane_count` (1, 2 or 4) affect the result.
- R4: The chosen swing is the largest swing request among the active lanes. The chosen pre-emphasis is the largest pre-emphasis request among the active lanes, and it may come from a different lane than the swing.
- R5: If the chosen swing is greater than or equal to `swing_limit`, the swing becomes `swing_limit` and the swing-max flag (bit 2) is set. Otherwise the flag is clear.
- R6: The pre-emphasis ceiling is looked up with the clamped swing: swing 0, 1, 2 and 3 give ceilings 3, 2, 1 and 0. If the chosen pre-emphasis is greater than or equal to the ceiling, it becomes the ceiling and the pre-emphasis-max flag (bit 5) is set.
- R7: Each lane byte has swing in bits [1:0], the swing-max flag in bit 2, pre-emphasis in bits [4:3], the pre-emphasis-max flag in bit 5, and zeros in bits [7:6]. All four slots carry the same byte, inactive lanes included. Lane i occupies `lane_bytes[8i+7:8i]`.
- R8: `all_max_swing` is high only when every active lane's byte has its swing-max flag set.
- R9: The outputs hold their values between operations, and changes on the request inputs alone do not alter them. A `start` that arrives during the `done` cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one adjustment |
| req_word | input | 16 | Per-lane swing and pre-emphasis requests |
| lane_count | input | 3 | Number of active lanes (1, 2 or 4) |
| swing_limit | input | 2 | Platform maximum swing level |
| lane_bytes | output | 32 | Four lane training bytes, lane 0 in the low byte |
| all_max_swing | output | 1 | Every active lane at maximum swing |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result of an operation is due exactly one cycle after the edge that samples `start`. The lane bytes, `all_max_swing` and `done` all appear together in that cycle, and `done` falls one cycle later. The bench drives inputs on falling edges. It reads all outputs on the falling edge that follows the capturing rising edge, and reads `done` again one edge later to confirm the pulse has ended. Checks that outputs hold are made after idle cycles in which the request inputs change with no `start`.

// File: rtl/ldadj_pkg.sv
package ldadj_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } ldadj_state_t;

    // Ceiling shrinks as swing grows: full scale minus swing, floored at 0.
    function automatic logic [7:0] pe_ceiling(input logic [7:0] swing_lvl,
                                              input logic [7:0] pe_full);
        if (swing_lvl >= pe_full) return 8'd0;
        return pe_full - swing_lvl;
    endfunction

endpackage

// File: rtl/ldadj_worst.sv
module ldadj_worst #(
    parameter int LANES = 4,
    parameter int SW_W  = 2,
    parameter int PE_W  = 2,
    parameter int CNT_W = 3
) (
    input  logic [LANES*(SW_W+PE_W)-1:0] req_word,
    input  logic [CNT_W-1:0]             lane_count,
    output logic [SW_W-1:0]              sw_worst,
    output logic [PE_W-1:0]              pe_worst
);
    localparam int NIB_W = SW_W + PE_W;

    logic [SW_W-1:0] sw_masked [LANES];
    logic [PE_W-1:0] pe_masked [LANES];

    // Inactive lanes contribute zero, which never wins a maximum.
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        logic lane_on;
        assign lane_on      = (CNT_W'(g) < lane_count);
        assign sw_masked[g] = lane_on ? req_word[g*NIB_W +: SW_W]        : '0;
        assign pe_masked[g] = lane_on ? req_word[g*NIB_W + SW_W +: PE_W] : '0;
    end

    always_comb begin
        sw_worst = '0;
        pe_worst = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sw_masked[i] > sw_worst) sw_worst = sw_masked[i];
            if (pe_masked[i] > pe_worst) pe_worst = pe_masked[i];
        end
    end
endmodule

// File: rtl/ldadj_clamp.sv
module ldadj_clamp
    import ldadj_pkg::*;
#(
    parameter int SW_W   = 2,
    parameter int PE_W   = 2,
    parameter int BYTE_W = 8
) (
    input  logic [SW_W-1:0]   sw_in,
    input  logic [PE_W-1:0]   pe_in,
    input  logic [SW_W-1:0]   sw_limit,
    output logic [BYTE_W-1:0] train_byte
);
    localparam int PAD_W = BYTE_W - SW_W - PE_W - 2;
    localparam logic [7:0] PE_FULL = 8'((1 << PE_W) - 1);

    logic [SW_W-1:0] sw_out;
    logic            sw_hit;
    logic [PE_W-1:0] pe_ceil;
    logic [PE_W-1:0] pe_out;
    logic            pe_hit;

    always_comb begin
        sw_hit = (sw_in >= sw_limit);
        sw_out = sw_hit ? sw_limit : sw_in;
    end

    // Ceiling is looked up with the swing after clamping.
    assign pe_ceil = PE_W'(pe_ceiling(8'(sw_out), PE_FULL));

    always_comb begin
        pe_hit = (pe_in >= pe_ceil);
        pe_out = pe_hit ? pe_ceil : pe_in;
    end

    assign train_byte = {{PAD_W{1'b0}}, pe_hit, pe_out, sw_hit, sw_out};
endmodule

// File: rtl/lane_drive_adjust.sv
module lane_drive_adjust
    import ldadj_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SW_W   = 2,
    parameter int PE_W   = 2,
    parameter int CNT_W  = 3,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [LANES*(SW_W+PE_W)-1:0] req_word,
    input  logic [CNT_W-1:0]             lane_count,
    input  logic [SW_W-1:0]              swing_limit,
    output logic [LANES*BYTE_W-1:0]      lane_bytes,
    output logic                         all_max_swing,
    output logic                         done
);
    localparam int SW_FLAG = SW_W;

    ldadj_state_t state_q, state_d;
    logic         accept;

    logic [SW_W-1:0]   sw_worst;
    logic [PE_W-1:0]   pe_worst;
    logic [BYTE_W-1:0] new_byte;
    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] slot_q [LANES];

    ldadj_worst #(
        .LANES(LANES), .SW_W(SW_W), .PE_W(PE_W), .CNT_W(CNT_W)
    ) u_worst (
        .req_word  (req_word),
        .lane_count(lane_count),
        .sw_worst  (sw_worst),
        .pe_worst  (pe_worst)
    );

    ldadj_clamp #(
        .SW_W(SW_W), .PE_W(PE_W), .BYTE_W(BYTE_W)
    ) u_clamp (
        .sw_in     (sw_worst),
        .pe_in     (pe_worst),
        .sw_limit  (swing_limit),
        .train_byte(new_byte)
    );

    // Next state: T_ACCEPT from idle on start, T_RETURN always back.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output process: done follows the report state.
    always_comb begin
        accept = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = start;
            ST_REPORT: done   = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         count_q <= '0;
        else if (accept) count_q <= lane_count;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)         slot_q[g] <= '0;
            else if (accept) slot_q[g] <= new_byte;
        end
        assign lane_bytes[g*BYTE_W +: BYTE_W] = slot_q[g];
    end

    always_comb begin
        all_max_swing = !rst && (count_q != '0);
        for (int i = 0; i < LANES; i++) begin
            if ((CNT_W'(i) < count_q) && !slot_q[i][SW_FLAG]) all_max_swing = 1'b0;
        end
    end
endmodule

// File: rtl/ldadj_checker.sv
module ldadj_checker #(
    parameter int LANES  = 4,
    parameter int SW_W   = 2,
    parameter int PE_W   = 2,
    parameter int BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic [LANES*BYTE_W-1:0] lane_bytes,
    input logic                    all_max_swing,
    input logic                    done
);
    localparam int PE_LO = SW_W + 1;
    localparam int PE_FULL = (1 << PE_W) - 1;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    logic [SW_W-1:0] sw0;
    logic [PE_W-1:0] pe0;
    assign sw0 = lane_bytes[SW_W-1:0];
    assign pe0 = lane_bytes[PE_LO +: PE_W];

    assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
        start && !done |=> done);
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_cause_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done && !rst_q |-> $stable(lane_bytes));
    assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        (32'(sw0) + 32'(pe0)) <= PE_FULL);
    assert_pe_flag_R6: assert property (@(posedge clk) disable iff (rst)
        lane_bytes[PE_LO+PE_W] |-> (32'(pe0) == PE_FULL - 32'(sw0)));
    assert_all_max_R8: assert property (@(posedge clk) disable iff (rst)
        all_max_swing |-> lane_bytes[SW_W]);

    for (genvar g = 1; g < LANES; g++) begin : g_same
        assert_same_slot_R7: assert property (@(posedge clk) disable iff (rst)
            lane_bytes[g*BYTE_W +: BYTE_W] == lane_bytes[BYTE_W-1:0]);
    end
endmodule

bind lane_drive_adjust ldadj_checker #(
    .LANES(LANES), .SW_W(SW_W), .PE_W(PE_W), .BYTE_W(BYTE_W)
) u_ldadj_checker (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .lane_bytes   (lane_bytes),
    .all_max_swing(all_max_swing),
    .done         (done)
);

// File: tb/lane_drive_adjust_test.sv
module lane_drive_adjust_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] req_word = '0;
    logic [2:0]  lane_count = 3'd4;
    logic [1:0]  swing_limit = 2'd3;
    logic [31:0] lane_bytes;
    logic        all_max_swing;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lane_drive_adjust uut (
        .clk(clk), .rst(rst), .start(start), .req_word(req_word),
        .lane_count(lane_count), .swing_limit(swing_limit),
        .lane_bytes(lane_bytes), .all_max_swing(all_max_swing), .done(done)
    );

    // {req[29:14], count[13:11], limit[10:9], byte[8:1], allmax[0]}
    localparam int NV = 11;
    localparam logic [29:0] VEC [NV] = '{
        {16'h0000, 3'd4, 2'd3, 8'h00, 1'b0},  // R4 all zero
        {16'h0061, 3'd4, 2'd3, 8'h2A, 1'b0},  // R4 R6 pre clamp at swing 2
        {16'hF001, 3'd2, 2'd3, 8'h01, 1'b0},  // R3 lane 3 ignored
        {16'h00F4, 3'd1, 2'd3, 8'h08, 1'b0},  // R3 one lane
        {16'h0003, 3'd4, 2'd2, 8'h06, 1'b1},  // R5 swing above limit
        {16'h0900, 3'd4, 2'd1, 8'h35, 1'b1},  // R5 R6 equal to limit and ceiling
        {16'h3000, 3'd4, 2'd3, 8'h27, 1'b1},  // R6 swing 3 ceiling 0
        {16'h3000, 3'd2, 2'd3, 8'h00, 1'b0},  // R3 high lanes inactive
        {16'h001C, 3'd2, 2'd3, 8'h31, 1'b0},  // R4 fields from different lanes
        {16'h0000, 3'd4, 2'd0, 8'h04, 1'b1},  // R5 limit zero
        {16'h0002, 3'd1, 2'd3, 8'h02, 1'b0}   // R6 below ceiling
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] rq, input logic [2:0] cnt, input logic [1:0] lim,
                          input logic [7:0] eb, input logic em, input string tag);
        @(negedge clk);
        req_word = rq; lane_count = cnt; swing_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 done"}, {31'd0, done}, 32'd1);
        check({tag, " R7 bytes"}, lane_bytes, {4{eb}});
        check({tag, " R8 all_max_swing"}, {31'd0, all_max_swing}, {31'd0, em});
        @(negedge clk);
        check({tag, " R2 done falls"}, {31'd0, done}, 32'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset bytes", lane_bytes, 32'h0);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset all_max_swing", {31'd0, all_max_swing}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][29:14], VEC[i][13:11], VEC[i][10:9], VEC[i][8:1], VEC[i][0],
                   $sformatf("vec%0d", i));
        end

        // R9 inputs change without start: outputs hold
        @(negedge clk);
        req_word = 16'hFFFF; lane_count = 3'd4; swing_limit = 2'd1;
        repeat (3) @(negedge clk);
        check("R9 hold bytes", lane_bytes, {4{8'h02}});
        check("R9 hold done", {31'd0, done}, 32'd0);

        // R9 start held two cycles: second one ignored during done
        run_op(16'h0003, 3'd4, 2'd3, 8'h27, 1'b1, "held_pre");
        @(negedge clk);
        req_word = 16'h0001; lane_count = 3'd4; swing_limit = 2'd3; start = 1'b1;
        @(negedge clk);
        check("R9 first done", {31'd0, done}, 32'd1);
        check("R9 first bytes", lane_bytes, {4{8'h01}});
        req_word = 16'h0002;
        @(negedge clk);
        start = 1'b0;
        check("R9 ignored start done", {31'd0, done}, 32'd0);
        check("R9 ignored start bytes", lane_bytes, {4{8'h01}});

        // R8 partial: swing flag low gives low flag even with 4 lanes
        run_op(16'h0002, 3'd4, 2'd3, 8'h02, 1'b0, "R8_low");

        // R1 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset bytes", lane_bytes, 32'h0);
        check("R1 mid reset all_max_swing", {31'd0, all_max_swing}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule